// File: doc/BRIEF.md
# Independent-Clock Watchdog with Sleep Wake

This block is a watchdog timer that counts on its own dedicated clock, so it keeps running when the core clock is gated off during a low-power sleep state. Software on the core restarts the count with a one-cycle clear request. If the count is allowed to run through a full period, the block signals a timeout. What the timeout does depends on the core's state. While the core is awake, the timeout becomes a one-cycle watchdog-reset pulse. While the core is asleep, it becomes a one-cycle wake pulse instead, and the core resumes with no reset.

The count lives entirely in the watchdog clock domain. Clear requests cross into that domain through a toggle synchronizer. Timeout events cross back into the core domain through a second toggle synchronizer. Because the timeout is carried as a level change rather than as a pulse, a timeout that happens while the core clock is stopped is held. It is delivered as exactly one wake pulse once the core clock runs again. A sticky status bit records that a timeout occurred. Power-on reset or a clear request clears it.

Top module: `indep_watchdog`

## Requirements
- R1: While `por_n` is low and after its release, `wdt_reset`, `wake` and `timeout_flag` are 0, and the count starts at zero.
- R2: With `enable` high and no clear request, a timeout occurs every 2^CW watchdog clocks (1024 with the default CW=10), and the count restarts from zero after each timeout.
- R3: A clear request (`kick` high for one core clock) restarts the count at zero, so clear requests spaced closer than one period prevent any timeout.
- R4: A timeout while `asleep` is 0 gives exactly one `wdt_reset` pulse, one core clock wide, and no `wake` pulse.
- R5: A timeout while `asleep` is 1 gives exactly one `wake` pulse, one core clock wide, and no `wdt_reset` pulse.
- R6: The count advances while the core clock is stopped. A timeout that occurs in that time produces no output until the core clock resumes, and then produces exactly one `wake` pulse.
- R7: `timeout_flag` goes to 1 in the same core cycle as the `wdt_reset` or `wake` pulse. It stays at 1 until a clear request, which returns it to 0 on the next core clock.
- R8: While `enable` is 0, the count is held at zero and no timeout occurs. After `enable` rises, the first timeout arrives one full period later.
- R9: `wdt_reset` and `wake` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| core_clk | input | 1 | Core clock; may be stopped while the core sleeps |
| wdt_clk | input | 1 | Free-running watchdog clock, asynchronous to `core_clk` |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| enable | input | 1 | Watchdog enable, quasi-static, synchronized into the watchdog domain |
| kick | input | 1 | Clear request, one `core_clk` cycle high per request |
| asleep | input | 1 | Core sleep-state indicator, core domain |
| wdt_reset | output | 1 | One-cycle reset request on a timeout while awake |
| wake | output | 1 | One-cycle wake request on a timeout while asleep |
| timeout_flag | output | 1 | Sticky timeout status |

## Verification
The assertions assume the following about the inputs. `kick` is a single-cycle pulse. Successive timeouts are far enough apart, much more than the synchronizer depth in either clock, for each toggle change to be seen on its own. `enable` and `asleep` change only while no timeout is in flight. The stimulus keeps to these assumptions in several ways. It drives `kick` for exactly one core cycle at a falling edge. It uses a 10-bit period against a three-to-one clock ratio, so timeouts are far apart. It changes `asleep` and `enable` only right after a power-on reset or well inside a period. It stops the core clock only in its low phase, so no partial pulse is produced.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // Default flop count of every synchronizer in the block (minimum 2).
  parameter int unsigned WDOG_SYNC_DEPTH = 2;
  // Default counter width: timeout period is 2**width watchdog clocks.
  parameter int unsigned WDOG_CNT_W      = 10;
endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync #(
  parameter int unsigned STAGES = wdog_pkg::WDOG_SYNC_DEPTH
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rst_n = sh_q[STAGES-1];
endmodule

// File: rtl/wdog_tog_sync.sv
module wdog_tog_sync #(
  parameter int unsigned STAGES = wdog_pkg::WDOG_SYNC_DEPTH
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_in,
  output logic pulse
);
  localparam int unsigned LEN = STAGES + 1;
  logic [LEN-1:0] sh_q;
  logic [LEN-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[LEN-2:0], tgl_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign pulse = sh_q[LEN-1] ^ sh_q[LEN-2];

  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CW     = wdog_pkg::WDOG_CNT_W,
  parameter int unsigned STAGES = wdog_pkg::WDOG_SYNC_DEPTH
) (
  input  logic wclk,
  input  logic rst_n,
  input  logic en_async,
  input  logic clr,
  output logic to_tgl
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic [STAGES-1:0] en_sh_q;
  logic              en_s;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              tgl_q, tgl_d;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) en_sh_q <= '0;
    else        en_sh_q <= {en_sh_q[STAGES-2:0], en_async};
  end
  assign en_s = en_sh_q[STAGES-1];

  always_comb begin
    cnt_d = cnt_q;
    tgl_d = tgl_q;
    if (!en_s || clr) begin
      cnt_d = '0;
    end else if (cnt_q == CNT_MAX) begin
      cnt_d = '0;
      tgl_d = ~tgl_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tgl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tgl_q <= tgl_d;
    end
  end

  assign to_tgl = tgl_q;

  // R2
  wrap_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    !$stable(tgl_q) |-> ($past(cnt_q) == CNT_MAX && cnt_q == '0));
  // R3
  clear_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
  // R8
  hold_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    !en_s |=> (cnt_q == '0 && $stable(tgl_q)));
endmodule

// File: rtl/indep_watchdog.sv
module indep_watchdog #(
  parameter int unsigned CW     = wdog_pkg::WDOG_CNT_W,
  parameter int unsigned STAGES = wdog_pkg::WDOG_SYNC_DEPTH
) (
  input  logic core_clk,
  input  logic wdt_clk,
  input  logic por_n,
  input  logic enable,
  input  logic kick,
  input  logic asleep,
  output logic wdt_reset,
  output logic wake,
  output logic timeout_flag
);
  logic core_rst_n, wdt_rst_n;
  logic kick_tgl_q, kick_tgl_d;
  logic clr_w;
  logic to_tgl_w;
  logic to_evt;
  logic rst_q, rst_d, wake_q, wake_d, flag_q, flag_d;

  wdog_rst_sync #(.STAGES(STAGES)) u_rs_core (
    .clk(core_clk), .arst_n(por_n), .rst_n(core_rst_n));
  wdog_rst_sync #(.STAGES(STAGES)) u_rs_wdt (
    .clk(wdt_clk), .arst_n(por_n), .rst_n(wdt_rst_n));

  // Core domain: clear request becomes a level change.
  always_comb begin
    kick_tgl_d = kick ? ~kick_tgl_q : kick_tgl_q;
  end

  wdog_tog_sync #(.STAGES(STAGES)) u_kick_xing (
    .clk(wdt_clk), .rst_n(wdt_rst_n), .tgl_in(kick_tgl_q), .pulse(clr_w));

  wdog_counter #(.CW(CW), .STAGES(STAGES)) u_cnt (
    .wclk(wdt_clk), .rst_n(wdt_rst_n), .en_async(enable),
    .clr(clr_w), .to_tgl(to_tgl_w));

  wdog_tog_sync #(.STAGES(STAGES)) u_to_xing (
    .clk(core_clk), .rst_n(core_rst_n), .tgl_in(to_tgl_w), .pulse(to_evt));

  // Steer timeout by sleep state; new timeout beats a same-cycle clear.
  always_comb begin
    rst_d  = to_evt & ~asleep;
    wake_d = to_evt &  asleep;
    flag_d = flag_q;
    if (to_evt)    flag_d = 1'b1;
    else if (kick) flag_d = 1'b0;
  end

  always_ff @(posedge core_clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      kick_tgl_q <= 1'b0;
      rst_q      <= 1'b0;
      wake_q     <= 1'b0;
      flag_q     <= 1'b0;
    end else begin
      kick_tgl_q <= kick_tgl_d;
      rst_q      <= rst_d;
      wake_q     <= wake_d;
      flag_q     <= flag_d;
    end
  end

  assign wdt_reset    = rst_q;
  assign wake         = wake_q;
  assign timeout_flag = flag_q;

  // R9
  excl_chk: assert property (@(posedge core_clk) disable iff (!core_rst_n)
    !(rst_q && wake_q));
  // R4
  rst_width_chk: assert property (@(posedge core_clk) disable iff (!core_rst_n)
    rst_q |=> !rst_q);
  // R5
  wake_state_chk: assert property (@(posedge core_clk) disable iff (!core_rst_n)
    wake_q |-> $past(asleep));
  // R7
  flag_set_chk: assert property (@(posedge core_clk) disable iff (!core_rst_n)
    (rst_q || wake_q) |-> flag_q);
  // R7
  flag_clr_chk: assert property (@(posedge core_clk) disable iff (!core_rst_n)
    (kick && !to_evt) |=> !flag_q);
endmodule

// File: tb/tb_indep_watchdog.sv
`timescale 1ns/1ps
module tb_indep_watchdog;
  localparam real TW     = 30.0;
  localparam real PERIOD = 1024.0 * TW;

  logic core_clk, wdt_clk, por_n, enable, kick, asleep;
  logic wdt_reset, wake, timeout_flag;
  logic clk_run;

  int total, bad;
  int rst_cnt, wake_cnt, both_cnt;
  realtime rst_t, wake_t, rel_t;

  indep_watchdog dut (
    .core_clk(core_clk), .wdt_clk(wdt_clk), .por_n(por_n),
    .enable(enable), .kick(kick), .asleep(asleep),
    .wdt_reset(wdt_reset), .wake(wake), .timeout_flag(timeout_flag));

  initial begin
    core_clk = 1'b0;
    forever begin
      #5;
      if (clk_run || core_clk) core_clk = ~core_clk;
    end
  end

  initial begin
    wdt_clk = 1'b0;
    forever #15 wdt_clk = ~wdt_clk;
  end

  always @(negedge core_clk) begin
    if (por_n) begin
      if (wdt_reset) begin rst_cnt++;  rst_t  = $realtime; end
      if (wake)      begin wake_cnt++; wake_t = $realtime; end
      if (wdt_reset && wake) both_cnt++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_por(input logic en, input logic slp);
    por_n = 1'b0; kick = 1'b0; enable = en; asleep = slp;
    #100;
    @(negedge core_clk);
    por_n = 1'b1;
    rel_t = $realtime;
    rst_cnt = 0; wake_cnt = 0; both_cnt = 0;
  endtask

  task automatic pulse_kick();
    @(negedge core_clk); kick = 1'b1;
    @(negedge core_clk); kick = 1'b0;
  endtask

  task automatic wait_events(input int n);
    for (int g = 0; g < 20000 && (rst_cnt + wake_cnt) < n; g++)
      @(negedge core_clk);
  endtask

  task automatic t_reset();
    por_n = 1'b0; enable = 1'b1; kick = 1'b0; asleep = 1'b0;
    #50;
    chk(!wdt_reset && !wake && !timeout_flag, "R1 outputs in reset",
        {wdt_reset, wake, timeout_flag}, 0);
    do_por(1'b1, 1'b0);
    repeat (20) @(negedge core_clk);
    chk(!wdt_reset && !wake && !timeout_flag, "R1 outputs after release",
        {wdt_reset, wake, timeout_flag}, 0);
  endtask

  task automatic t_free_run();
    realtime first, dt;
    do_por(1'b1, 1'b0);
    wait_events(1);
    first = rst_t;
    dt = first - rel_t;
    chk(dt >= PERIOD && dt <= PERIOD + 12 * TW, "R2 first timeout time",
        int'(dt), int'(PERIOD));
    chk(rst_cnt == 1 && wake_cnt == 0, "R4 reset pulse awake", rst_cnt, 1);
    chk(timeout_flag == 1'b1, "R7 flag set", timeout_flag, 1);
    wait_events(2);
    dt = rst_t - first;
    chk(dt >= PERIOD - 10.0 && dt <= PERIOD + 10.0, "R2 repeat period",
        int'(dt), int'(PERIOD));
    chk(rst_cnt == 2 && wake_cnt == 0, "R4 one pulse per timeout", rst_cnt, 2);
  endtask

  task automatic t_kick();
    realtime last, dt;
    do_por(1'b1, 1'b0);
    for (int k = 0; k < 4; k++) begin
      #(600.0 * TW);
      pulse_kick();
    end
    last = $realtime;
    chk(rst_cnt == 0 && wake_cnt == 0, "R3 kicks prevent timeout",
        rst_cnt + wake_cnt, 0);
    chk(timeout_flag == 1'b0, "R7 flag clear without timeout", timeout_flag, 0);
    wait_events(1);
    dt = rst_t - last;
    chk(dt >= PERIOD - 2 * TW && dt <= PERIOD + 12 * TW, "R3 period after kick",
        int'(dt), int'(PERIOD));
    chk(timeout_flag == 1'b1, "R7 flag set on timeout", timeout_flag, 1);
    repeat (50) @(negedge core_clk);
    chk(timeout_flag == 1'b1, "R7 flag sticky", timeout_flag, 1);
    pulse_kick();
    chk(timeout_flag == 1'b0, "R7 flag cleared by kick", timeout_flag, 0);
  endtask

  task automatic t_sleep();
    do_por(1'b1, 1'b1);
    wait_events(1);
    repeat (5) @(negedge core_clk);
    chk(wake_cnt == 1 && rst_cnt == 0, "R5 wake while asleep", wake_cnt, 1);
    chk(timeout_flag == 1'b1, "R7 flag on wake", timeout_flag, 1);
  endtask

  task automatic t_stopped();
    do_por(1'b1, 1'b1);
    repeat (100) @(negedge core_clk);
    clk_run = 1'b0;
    #(1500.0 * TW);
    chk(wake_cnt == 0 && rst_cnt == 0 && wake == 1'b0,
        "R6 silent while clock stopped", wake_cnt, 0);
    clk_run = 1'b1;
    repeat (12) @(negedge core_clk);
    chk(wake_cnt == 1 && rst_cnt == 0, "R6 wake after clock resumes",
        wake_cnt, 1);
  endtask

  task automatic t_disable();
    realtime t_en, dt;
    do_por(1'b0, 1'b0);
    #(2500.0 * TW);
    chk(rst_cnt == 0 && wake_cnt == 0 && timeout_flag == 1'b0,
        "R8 no timeout while disabled", rst_cnt + wake_cnt, 0);
    @(negedge core_clk);
    enable = 1'b1;
    t_en = $realtime;
    wait_events(1);
    dt = rst_t - t_en;
    chk(dt >= PERIOD && dt <= PERIOD + 12 * TW, "R8 full period after enable",
        int'(dt), int'(PERIOD));
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0; clk_run = 1'b1;
    rst_cnt = 0; wake_cnt = 0; both_cnt = 0;
    por_n = 1'b0; enable = 1'b0; kick = 1'b0; asleep = 1'b0;
    t_reset();
    t_free_run();
    chk(both_cnt == 0, "R9 exclusive outputs", both_cnt, 0);
    t_kick();
    t_sleep();
    chk(both_cnt == 0, "R9 exclusive outputs asleep", both_cnt, 0);
    t_stopped();
    t_disable();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule